// File: doc/BRIEF.md
# Dual-Edge Time-over-Threshold Counter

This block measures how long a pixel discriminator output stays high. It takes a hit level and counts it on both the rising and the falling edge of a bunch-crossing clock. A 40 MHz clock therefore gives a time step of 12.5 ns, with no faster clock. The result is a 5-bit code that covers up to 400 ns. Longer hits report the top code and do not wrap.

Two small counters do the work. One runs on the rising edge and one on the falling edge, and each counts the edges at which the hit level is high. No logic runs from a gated clock. On the first rising edge at which the hit is low again, the sum of the two counters is turned into a code. That code is stored in the output register, a one-cycle done strobe is raised, and both counters are cleared for the next hit. The first edge that sees the hit marks its arrival. Each further edge that sees it adds one completed half-period.

Top module: `tot_meter`

## Requirements
- R1: The reset is synchronous and active-high. During reset and in the cycle after it, `tot_o` is 0 and `done_o` is 0.
- R2: Every rising and every falling clock edge at which `hit_i` is high counts as one sample. The result does not depend on whether a hit begins after a rising edge or after a falling edge.
- R3: A hit seen at N samples, with N from 1 to 32, reports `tot_o` = N-1 as an unsigned binary number.
- R4: A hit seen at 32 or more samples reports 31 (all ones). The code never wraps, however long the hit lasts.
- R5: `done_o` is high for exactly the clock cycle after the first rising edge at which `hit_i` is low, following a hit that was seen at one or more samples. `tot_o` takes its new value at that same edge.
- R6: A hit seen at exactly one sampling edge reports 0 and still raises `done_o`.
- R7: `tot_o` changes only in a cycle in which `done_o` is high. Between results it holds the last result.
- R8: A pulse that rises and falls between two neighbouring clock edges touches no sample. It raises no `done_o` and leaves `tot_o` unchanged.
- R9: A new hit that starts just after the rising edge that produced a result is measured from zero. No sample from the earlier hit is carried into it, and none of its own samples is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bunch-crossing clock; both edges are used for sampling |
| rst_i | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Discriminator level, high while over threshold |
| tot_o | output | TOT_W (5) | Registered time-over-threshold code of the last hit |
| done_o | output | 1 | One-cycle strobe marking a new value on `tot_o` |

## Verification
The bench builds the block with its default `TOT_W` of 5. This gives a per-counter limit of 32 samples and a top code of 31. With these values, hits of 31, 32, 33, 40 and 70 samples are short enough to drive directly, so the last exact code, the first saturated code and deep saturation are all reached. The 70-sample hit also drives both edge counters into their own limits.

Hits are started after either clock edge so that each counter leads in turn. A sub-half-period glitch and a hit that starts just after a result edge exercise the clear path of the falling-edge counter.

// File: rtl/tot_pkg.sv
package tot_pkg;

  // Which clock edge a sampling counter runs on.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } tot_edge_e;

endpackage

// File: rtl/tot_edge_counter.sv
module tot_edge_counter
  import tot_pkg::*;
#(
  parameter int        SAMP_W = 6,
  parameter int        LIMIT  = 32,
  parameter tot_edge_e EDGE   = EDGE_RISE
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic              hit_i,
  output logic [SAMP_W-1:0] cnt_o
);

  localparam logic [SAMP_W-1:0] CapVal = SAMP_W'(LIMIT);

  logic [SAMP_W-1:0] cnt_q;
  logic [SAMP_W-1:0] cnt_d;

  // Shared next-state logic. A clear keeps the sample taken at this edge,
  // so a hit that is already back does not lose its first count.
  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = hit_i ? SAMP_W'(1) : '0;
    end else if (hit_i && (cnt_q < CapVal)) begin
      cnt_d = cnt_q + SAMP_W'(1);
    end
  end

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
      end
    end else begin : g_fall
      always_ff @(negedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
      end
    end
  endgenerate

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tot_result.sv
module tot_result #(
  parameter int TOT_W  = 5,
  parameter int SAMP_W = 6,
  parameter int LIMIT  = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hit_i,
  input  logic [SAMP_W-1:0] rise_cnt_i,
  input  logic [SAMP_W-1:0] fall_cnt_i,
  output logic              done_set_o,
  output logic [TOT_W-1:0]  tot_o,
  output logic              done_o
);

  localparam int               SumW   = SAMP_W + 1;
  localparam logic [TOT_W-1:0] TopVal = {TOT_W{1'b1}};

  logic [SumW-1:0]  sum;
  logic [TOT_W-1:0] code;
  logic             done_set;
  logic [TOT_W-1:0] tot_q;
  logic             done_q;

  assign sum = SumW'(rise_cnt_i) + SumW'(fall_cnt_i);

  // First sample marks arrival; each further sample is one half-period.
  always_comb begin
    if (sum == '0) begin
      code = '0;
    end else if (sum > SumW'(LIMIT)) begin
      code = TopVal;
    end else begin
      code = TOT_W'(sum - SumW'(1));
    end
  end

  assign done_set = !hit_i && (sum != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tot_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_set;
      if (done_set) tot_q <= code;
    end
  end

  assign done_set_o = done_set;
  assign tot_o      = tot_q;
  assign done_o     = done_q;

endmodule

// File: rtl/tot_meter.sv
module tot_meter
  import tot_pkg::*;
#(
  parameter int TOT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hit_i,
  output logic [TOT_W-1:0] tot_o,
  output logic             done_o
);

  localparam int Limit = 2 ** TOT_W;            // samples that fill the code
  localparam int SampW = $clog2(Limit + 1);

  logic [SampW-1:0] rise_cnt;
  logic [SampW-1:0] fall_cnt;
  logic             done_set;
  logic             done_q;

  // Rising-edge counter clears at the result edge itself.
  tot_edge_counter #(
    .SAMP_W (SampW),
    .LIMIT  (Limit),
    .EDGE   (EDGE_RISE)
  ) u_rise (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (done_set),
    .hit_i  (hit_i),
    .cnt_o  (rise_cnt)
  );

  // Falling-edge counter clears half a period later, from the strobe.
  tot_edge_counter #(
    .SAMP_W (SampW),
    .LIMIT  (Limit),
    .EDGE   (EDGE_FALL)
  ) u_fall (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (done_q),
    .hit_i  (hit_i),
    .cnt_o  (fall_cnt)
  );

  tot_result #(
    .TOT_W  (TOT_W),
    .SAMP_W (SampW),
    .LIMIT  (Limit)
  ) u_result (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hit_i      (hit_i),
    .rise_cnt_i (rise_cnt),
    .fall_cnt_i (fall_cnt),
    .done_set_o (done_set),
    .tot_o      (tot_o),
    .done_o     (done_q)
  );

  assign done_o = done_q;

endmodule

// File: rtl/tot_meter_checker.sv
module tot_meter_checker #(
  parameter int TOT_W = 5
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             hit_i,
  input logic [TOT_W-1:0] tot_o,
  input logic             done_o
);

  localparam logic [TOT_W-1:0] TopVal = {TOT_W{1'b1}};

  // Rising edges seen high in the current run of the hit level.
  logic [7:0] run_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)                    run_q <= '0;
    else if (!hit_i)              run_q <= '0;
    else if (run_q != 8'hFF)      run_q <= run_q + 8'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    rst_i |=> (tot_o == '0) && !done_o);                              // R1

  AST_DONE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !$past(hit_i));                                        // R5

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(tot_o) |-> done_o);                                      // R7

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && ($past(run_q) >= 8'd17)) |-> (tot_o == TopVal));       // R4

endmodule

bind tot_meter tot_meter_checker #(.TOT_W(TOT_W)) u_tot_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .hit_i  (hit_i),
  .tot_o  (tot_o),
  .done_o (done_o)
);

// File: tb/test_tot_meter.sv
`timescale 1ns/1ps
module test_tot_meter;

  localparam int CLK_PERIOD = 25;
  localparam int TOT_W      = 5;
  localparam int TOP        = 2 ** TOT_W - 1;

  logic             clk_i = 1'b0;
  logic             rst_i = 1'b1;
  logic             hit_i = 1'b0;
  logic [TOT_W-1:0] tot_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  int last_exp = 0;
  bit finished = 1'b0;

  tot_meter #(.TOT_W(TOT_W)) i_tot_meter (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hit_i  (hit_i),
    .tot_o  (tot_o),
    .done_o (done_o)
  );

  always #(CLK_PERIOD / 2.0) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pop one expected result per strobe, sampled mid-cycle.
  always @(negedge clk_i) begin
    if (!rst_i && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(tot_o == TOT_W'(e), t, int'(tot_o), e);
      end
    end
  end

  // Called 2 ns after a clock edge: hold hit for n sampling edges.
  task automatic drive_high(input int n);
    int e;
    string t;
    hit_i = 1'b1;
    repeat (n) @(clk_i);
    #2 hit_i = 1'b0;
    e = (n - 1 > TOP) ? TOP : n - 1;
    if (n >= TOP + 1)  t = "R4 saturated code";
    else if (n == 1)   t = "R6 single sample";
    else               t = "R3/R2 sample count";
    exp_q.push_back(e);
    tag_q.push_back(t);
    last_exp = e;
  endtask

  // Strobe must be visible right after the next rising edge.
  task automatic expect_done();
    @(posedge clk_i);
    #1 check(done_o == 1'b1, "R5 done after fall", int'(done_o), 1);
  endtask

  task automatic pulse(input int n, input bit after_fall);
    if (after_fall) @(negedge clk_i); else @(posedge clk_i);
    #2 drive_high(n);
    expect_done();
    repeat (3) @(posedge clk_i);
    #1 check(tot_o == TOT_W'(last_exp), "R7 value held", int'(tot_o), last_exp);
    check(done_o == 1'b0, "R5 strobe one cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk_i);
      check(tot_o == '0 && done_o == 1'b0, "R1 in reset", int'(tot_o), 0);
    end
    @(posedge clk_i); #1 rst_i = 1'b0;
    @(negedge clk_i);
    check(tot_o == '0 && done_o == 1'b0, "R1 after reset", int'(tot_o), 0);

    // R2/R3: both start phases, short and medium lengths
    pulse(1, 1'b0);
    pulse(1, 1'b1);
    pulse(2, 1'b0);
    pulse(3, 1'b1);
    pulse(10, 1'b0);
    pulse(11, 1'b1);
    // R3/R4 boundary and saturation
    pulse(31, 1'b0);
    pulse(32, 1'b1);
    pulse(33, 1'b0);
    pulse(40, 1'b1);
    pulse(70, 1'b0);
    pulse(5, 1'b0);

    // R8: glitch that touches no edge
    @(posedge clk_i);
    #2 hit_i = 1'b1;
    #5 hit_i = 1'b0;
    repeat (4) @(posedge clk_i);
    #1 check(tot_o == TOT_W'(last_exp), "R8 glitch ignored", int'(tot_o), last_exp);

    // R9: second hit starts just after the result edge of the first
    @(posedge clk_i);
    #2 drive_high(6);
    expect_done();
    #1 drive_high(4);
    expect_done();
    repeat (3) @(posedge clk_i);
    #1 check(tot_o == TOT_W'(3), "R9 next hit from zero", int'(tot_o), 3);

    repeat (2) @(posedge clk_i);
    check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule